// File: doc/BRIEF.md
# Limb-Serial Modular Product Array

This block forms the fifteen partial sums of the product of two 255-bit operands in the prime field of modulus 2^255-19, before any collapsing or carry handling. Each operand is cut into fifteen 17-bit limbs. One multiply-accumulate column exists for every limb of the first operand A. When a run is accepted, each column stores its own A limb together with nineteen times that limb. Those coefficients then stay in place for the whole run.

In every round one limb of the second operand B is broadcast to all columns. Each column multiplies it by one of its two stored coefficients. The running sums travel one column down a ring after every round. A product that would land above limb fourteen is wrapped back to the bottom of the field, and the column takes its 19-scaled coefficient for it. The reduction by 19 is therefore folded into the multiply. Fifteen multiply rounds and one drain step bring each sum back to the column of its own row, and a done pulse then marks the result. The sums stay on the outputs until the next accepted start. A downstream stage collapses them and propagates the carries.

Top module: `mpa_array`

## Requirements
- R1: After reset, done_o is low and every partial-sum lane of sum_o is zero.
- R2: Limb k of an operand is bits [17k+16:17k] of a_i or b_i, for k = 0 to 14.
- R3: When a run completes, lane r equals the sum over c = 0..14 of coef(r,c)*B[c]. Here coef(r,c) is A[r-c] when r >= c, and 19*A[15+r-c] when r < c.
- R4: A start accepted at a clock edge raises done_o exactly 16 cycles later, and done_o stays high for one cycle only.
- R5: From the done pulse until the next accepted start, sum_o holds its value, whatever a_i and b_i do.
- R6: A start_i pulse during a run is ignored. That run's result and done timing are those of the operands latched at its own start.
- R7: Each lane is 48 bits wide and never overflows, even for all-ones operands. No lane ever exceeds 15*19*(2^17-1)^2.
- R8: A start presented in the cycle where done_o is high is accepted, and it begins a new run at once.
- R9: Lane r of sum_o occupies bits [48r+47:48r].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| a_i | input | 255 | Operand A, fifteen 17-bit limbs |
| b_i | input | 255 | Operand B, fifteen 17-bit limbs |
| done_o | output | 1 | One-cycle pulse when the partial sums are valid |
| sum_o | output | 720 | Fifteen 48-bit unreduced partial sums |

## Verification
The assertions assume that start_i is a clean synchronous level, and that a_i and b_i matter only in the cycle where a start is accepted. The latency and stability properties count only starts the block accepts. The stimulus drives every input at the falling edge. It raises start_i for exactly one cycle per request, and it changes the operands freely while a run is in flight or the block sits idle, which exercises both assumptions. The overflow bound assumes limbs of at most 17 bits. The all-ones operands reach the largest sums the port width allows.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
    localparam int unsigned MPA_LIMBS  = 15;
    localparam int unsigned MPA_LIMB_W = 17;
    localparam int unsigned MPA_ACC_W  = 48;
    localparam int unsigned MPA_FOLD   = 19;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_phase_e;
endpackage

// File: rtl/mpa_sequencer.sv
module mpa_sequencer
    import mpa_pkg::*;
#(
    parameter int unsigned LIMBS = MPA_LIMBS,
    localparam int unsigned CNT_W = $clog2(LIMBS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic             load_o,
    output logic             busy_o,
    output logic             fire_o,
    output logic [CNT_W-1:0] round_o,
    output logic             done_o
);
    typedef struct packed {
        seq_phase_e       phase;
        logic [CNT_W-1:0] round;
        logic             done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load_o    = start_i && (st_q.phase == SEQ_IDLE);
        if (load_o) begin
            st_d.phase = SEQ_RUN;
            st_d.round = '0;
        end else if (st_q.phase == SEQ_RUN) begin
            if (st_q.round == CNT_W'(LIMBS)) begin
                st_d.phase = SEQ_IDLE;
                st_d.round = '0;
                st_d.done  = 1'b1;
            end else begin
                st_d.round = st_q.round + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: SEQ_IDLE, round: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.phase == SEQ_RUN);
    assign fire_o  = busy_o && (st_q.round < CNT_W'(LIMBS));
    assign round_o = st_q.round;
    assign done_o  = st_q.done;
endmodule

// File: rtl/mpa_column.sv
module mpa_column
    import mpa_pkg::*;
#(
    parameter int unsigned IDX    = 0,
    parameter int unsigned LIMBS  = MPA_LIMBS,
    parameter int unsigned LIMB_W = MPA_LIMB_W,
    parameter int unsigned FOLD   = MPA_FOLD,
    localparam int unsigned CNT_W  = $clog2(LIMBS + 1),
    localparam int unsigned COEF_W = LIMB_W + $clog2(FOLD),
    localparam int unsigned PROD_W = COEF_W + LIMB_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              fire_i,
    input  logic [CNT_W-1:0]  round_i,
    input  logic [LIMB_W-1:0] a_limb_i,
    input  logic [LIMB_W-1:0] b_limb_i,
    output logic [PROD_W-1:0] prod_o
);
    typedef struct packed {
        logic [LIMB_W-1:0] a;
        logic [COEF_W-1:0] a_fold;
        logic [PROD_W-1:0] prod;
    } col_st_t;

    col_st_t st_d, st_q;
    logic              wrap;
    logic [COEF_W-1:0] coef;

    // the product for this column wraps past the top limb once IDX+round reaches LIMBS
    assign wrap = (int'(IDX) + int'(round_i)) >= int'(LIMBS);
    assign coef = wrap ? st_q.a_fold : COEF_W'(st_q.a);

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.a      = a_limb_i;
            st_d.a_fold = COEF_W'(FOLD) * COEF_W'(a_limb_i);
            st_d.prod   = '0;
        end else if (fire_i) begin
            st_d.prod = PROD_W'(coef) * PROD_W'(b_limb_i);
        end else begin
            st_d.prod = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod_o = st_q.prod;
endmodule

// File: rtl/mpa_array.sv
module mpa_array
    import mpa_pkg::*;
#(
    parameter int unsigned LIMBS  = MPA_LIMBS,
    parameter int unsigned LIMB_W = MPA_LIMB_W,
    parameter int unsigned ACC_W  = MPA_ACC_W,
    parameter int unsigned FOLD   = MPA_FOLD,
    localparam int unsigned OP_W   = LIMBS * LIMB_W,
    localparam int unsigned SUM_W  = LIMBS * ACC_W,
    localparam int unsigned CNT_W  = $clog2(LIMBS + 1),
    localparam int unsigned COEF_W = LIMB_W + $clog2(FOLD),
    localparam int unsigned PROD_W = COEF_W + LIMB_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    output logic             done_o,
    output logic [SUM_W-1:0] sum_o
);
    typedef struct packed {
        logic [OP_W-1:0]             b;
        logic [LIMBS-1:0][ACC_W-1:0] acc;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                         load_w, busy_w, fire_w;
    logic [CNT_W-1:0]             round_w;
    logic [LIMBS-1:0][PROD_W-1:0] prod_w;

    mpa_sequencer #(.LIMBS(LIMBS)) seq_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .load_o  (load_w),
        .busy_o  (busy_w),
        .fire_o  (fire_w),
        .round_o (round_w),
        .done_o  (done_o)
    );

    for (genvar g = 0; g < LIMBS; g++) begin : g_col
        mpa_column #(
            .IDX    (g),
            .LIMBS  (LIMBS),
            .LIMB_W (LIMB_W),
            .FOLD   (FOLD)
        ) col_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .load_i   (load_w),
            .fire_i   (fire_w),
            .round_i  (round_w),
            .a_limb_i (a_i[g*LIMB_W +: LIMB_W]),
            .b_limb_i (st_q.b[LIMB_W-1:0]),
            .prod_o   (prod_w[g])
        );
    end

    // each round, the sum held by column i absorbs that column's product and moves to column i-1 (ring)
    always_comb begin
        st_d = st_q;
        if (load_w) begin
            st_d.b   = b_i;
            st_d.acc = '0;
        end else if (busy_w) begin
            if (fire_w) begin
                st_d.b = st_q.b >> LIMB_W;
            end
            for (int i = 0; i < LIMBS; i++) begin
                st_d.acc[(i == 0) ? (LIMBS - 1) : (i - 1)] = st_q.acc[i] + ACC_W'(prod_w[i]);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o = st_q.acc;
endmodule

// File: rtl/mpa_array_chk.sv
module mpa_array_chk #(
    parameter int unsigned LIMBS  = 15,
    parameter int unsigned LIMB_W = 17,
    parameter int unsigned ACC_W  = 48,
    parameter int unsigned FOLD   = 19,
    localparam int unsigned CNT_W = $clog2(LIMBS + 1)
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   done_o,
    input logic [LIMBS*ACC_W-1:0] sum_o,
    input logic                   busy,
    input logic                   load,
    input logic [CNT_W-1:0]       round
);
    localparam longint unsigned LIMB_MAX = (64'd1 << LIMB_W) - 64'd1;
    localparam longint unsigned BOUND    = 64'(LIMBS) * 64'(FOLD) * LIMB_MAX * LIMB_MAX;

    logic             run_q;
    logic [CNT_W:0]   cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == (CNT_W+1)'(LIMBS + 1)) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4: done appears exactly LIMBS+1 cycles after an accepted start, and at no other time
    p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o == (run_q && (cnt_q == (CNT_W+1)'(LIMBS + 1))));

    // R4: done is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R5: with no run and no accepted start, the sums do not move
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && !load) |=> $stable(sum_o));

    // R6: a run never restarts its round count before finishing
    p_no_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && round != '0) |=> (round == $past(round) + 1'b1) || !busy);

    p_round_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        round <= CNT_W'(LIMBS));

    for (genvar g = 0; g < LIMBS; g++) begin : g_lane
        // R7: every lane stays within the worst-case partial-sum bound
        p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            64'(sum_o[g*ACC_W +: ACC_W]) <= BOUND);
    end
endmodule

bind mpa_array mpa_array_chk #(
    .LIMBS  (LIMBS),
    .LIMB_W (LIMB_W),
    .ACC_W  (ACC_W),
    .FOLD   (FOLD)
) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (done_o),
    .sum_o  (sum_o),
    .busy   (busy_w),
    .load   (load_w),
    .round  (round_w)
);

// File: tb/mpa_array_tb_top.sv
module mpa_array_tb_top;
    localparam int NL = 15;
    localparam int LW = 17;
    localparam int AW = 48;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [NL*LW-1:0] a_i = '0;
    logic [NL*LW-1:0] b_i = '0;
    logic             done_o;
    logic [NL*AW-1:0] sum_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mpa_array dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .done_o  (done_o),
        .sum_o   (sum_o)
    );

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R3: wrapped schoolbook sums, limb k at bits [17k+16:17k] (R2)
    function automatic longint unsigned ref_lane(input logic [NL*LW-1:0] a, b, input int r);
        longint unsigned s = 0;
        for (int c = 0; c < NL; c++) begin
            longint unsigned bl = 64'(b[c*LW +: LW]);
            longint unsigned al;
            if (r >= c) al = 64'(a[(r-c)*LW +: LW]);
            else        al = 19 * 64'(a[(NL+r-c)*LW +: LW]);
            s += al * bl;
        end
        return s;
    endfunction

    // R9: lane r at bits [48r+47:48r]
    task automatic check_sums(input logic [NL*LW-1:0] a, b, input string req);
        for (int r = 0; r < NL; r++) begin
            longint unsigned act = 64'(sum_o[r*AW +: AW]);
            longint unsigned exp = ref_lane(a, b, r);
            check(act == exp, req, act, exp);
        end
    endtask

    function automatic logic [NL*LW-1:0] rnd_op();
        logic [NL*LW-1:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v[NL*LW-1:0];
    endfunction

    // precondition: a_i, b_i driven with (a,b) and start_i high at a negedge
    task automatic go(input logic [NL*LW-1:0] a, b, input bit poke, input bit chain,
                      input logic [NL*LW-1:0] na, nb, input string req);
        int got = -1;
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            if (done_o && got < 0) got = n;
            if (poke && n == 5) begin a_i = ~a; b_i = ~b; start_i = 1'b1; end
            if (poke && n == 6) start_i = 1'b0;
            if (n == 16) begin
                check_sums(a, b, req);
                if (chain) begin a_i = na; b_i = nb; start_i = 1'b1; break; end
            end
            if (n == 17) begin
                check(!done_o, "R4 pulse width", 64'(done_o), 0);
                a_i = rnd_op(); b_i = rnd_op();
            end
            if (n == 20) check_sums(a, b, "R5 hold after done");
        end
        check(got == 16, "R4 latency", 64'(got), 16);
    endtask

    task automatic run(input logic [NL*LW-1:0] a, b, input string req);
        a_i = a; b_i = b; start_i = 1'b1;
        go(a, b, 1'b0, 1'b0, '0, '0, req);
    endtask

    initial begin
        logic [NL*LW-1:0] ones, x, y, z, w;
        void'($urandom(32'd1234));
        ones = '1;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1 done at reset", 64'(done_o), 0);
        check(sum_o == '0, "R1 sums at reset", 64'(sum_o[63:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sum_o == '0, "R1 sums after release", 64'(sum_o[63:0]), 0);

        run('0, '0, "R3 zero operands");
        run(ones, ones, "R7 all ones");
        // R2: A limb 14 times B limb 1 wraps to lane 0 with factor 19
        x = '0; x[14*LW +: LW] = 17'h1ABCD;
        y = '0; y[1*LW +: LW]  = 17'h00F31;
        run(x, y, "R2 wrap lane 0");
        // A limb 3 times B limb 2 lands unscaled on lane 5
        x = '0; x[3*LW +: LW] = 17'h1FFFF;
        y = '0; y[2*LW +: LW] = 17'h12345;
        run(x, y, "R3 unscaled lane 5");
        run(ones, 255'd1, "R3 B equals one");

        // R6: start during a run is ignored
        x = rnd_op(); y = rnd_op();
        a_i = x; b_i = y; start_i = 1'b1;
        go(x, y, 1'b1, 1'b0, '0, '0, "R6 start while busy");

        // R8: back-to-back start in the done cycle
        x = rnd_op(); y = rnd_op(); z = rnd_op(); w = rnd_op();
        a_i = x; b_i = y; start_i = 1'b1;
        go(x, y, 1'b0, 1'b1, z, w, "R8 first of pair");
        go(z, w, 1'b0, 1'b0, '0, '0, "R8 second of pair");

        for (int t = 0; t < 20; t++) begin
            x = rnd_op(); y = rnd_op();
            run(x, y, "R3 random");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R4 watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule